// File: doc/BRIEF.md
# SPI Master/Slave Serial Port

This block is a byte-wide synchronous serial port. It runs as either an SPI master or an SPI slave, and a 4-bit mode field in its control register selects which. The same register holds an enable bit, the idle clock level and two sticky error flags. The host starts a transfer by writing the data buffer, and it collects each received byte by reading that buffer.

As a master, the port makes its serial clock in one of two ways. It can divide the system clock by 4, 16 or 64. It can also toggle the clock once per pulse of an external timer tick, so that the serial clock runs at half the tick rate. As a slave, it follows an external serial clock. In one slave mode the port listens only while the active-low select input is low. In the other slave mode it ignores the select input.

Bits leave most significant first. Each bit is driven on the clock edge that leaves the idle level and sampled on the edge that returns to it. A received byte goes into the buffer and sets a full flag. If the host writes the buffer during a transfer, the write is refused and the collision flag is set. In slave mode, if a byte completes while the buffer is still full, the new byte is lost and the overflow flag is set.

Top module: `spi_port`

## Requirements
- R1: Control bits [3:0] hold the mode and bit [5] is the enable. Mode 0000 makes the port a master whose SCK changes level every 2 system clocks (divide by 4). Mode 0001 makes it change every 8 clocks (divide by 16), and mode 0010 every 32 clocks (divide by 64).
- R2: In mode 0011 the master's SCK changes level once per one-cycle pulse on `tickIn`, so the clock period is two ticks.
- R3: A transfer moves 8 bits in both directions at once, most significant bit first. SDO changes on the edge that leaves the idle level, and SDI is sampled on the edge that returns to it. When the byte completes, it is loaded into the buffer and `bufFull` rises.
- R4: A buffer read strobe (`bufRe`) clears `bufFull`.
- R5: Control bit [7] is the write-collision flag. It is set when the buffer is written while a byte is being shifted, and that write is ignored. Writing the control register with bit [7] at 0 clears the flag. Writing it with bit [7] at 1 leaves the flag set.
- R6: Control bit [6] is the overflow flag. It is set when a slave byte completes while `bufFull` is 1. The new byte is discarded and the buffer keeps the old byte. Writing 0 to bit [6] clears the flag.
- R7: The overflow flag never sets in master modes 0000 to 0011. A new master byte replaces the buffer contents.
- R8: In mode 0100 (slave with select), SDO is driven only while `ssNIn` is low. Raising `ssNIn` in the middle of a byte resets the bit count, so the next full byte is received correctly.
- R9: In mode 0101 (slave without select), transfers run while `ssNIn` is held high.
- R10: When the enable bit is 0, or the mode is a reserved value from 0110 to 1111, `sckOe` and `sdoOe` are 0 and a buffer write starts no clocking.
- R11: Control bit [4] sets the SCK idle level: 1 means idle high and 0 means idle low. Outside a master transfer, `sckOut` equals this bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWe | input | 1 | Control register write strobe |
| ctrlWdata | input | 8 | Control write data: {collision, overflow, enable, polarity, mode[3:0]} |
| ctrlRdata | output | 8 | Control register readback, same layout as the write data |
| bufWe | input | 1 | Data buffer write strobe |
| bufWdata | input | 8 | Byte to transmit |
| bufRe | input | 1 | Data buffer read strobe |
| bufRdata | output | 8 | Last received byte |
| bufFull | output | 1 | A received byte has not been read yet |
| tickIn | input | 1 | External timer tick for mode 0011 |
| sckIn | input | 1 | Serial clock input for the slave modes |
| sckOut | output | 1 | Serial clock output for the master modes |
| sckOe | output | 1 | Output enable for SCK |
| sdiIn | input | 1 | Serial data input |
| sdoOut | output | 1 | Serial data output |
| sdoOe | output | 1 | Output enable for SDO |
| ssNIn | input | 1 | Active-low slave select |

## Verification
The checks assume the following about the inputs:
- Host strobes last one cycle.
- In slave mode, each SCK half-period is longer than the input synchronizer delay.
- SDI is stable around the returning edge.
- The select input changes only while SCK is idle.

The bench keeps to these assumptions. It drives every slave half-period for eight system clocks, it changes SDI together with the leaving edge, and it moves the select input only with SCK at its idle level. The bench drives `tickIn` as single-cycle pulses five clocks apart. It changes the polarity or the mode only while no byte is in flight.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  // Strobes from the control path into the datapath
  typedef struct packed {
    logic loadTx;    // load the transmit byte into the shifter
    logic driveOut;  // present the shifter MSB on SDO (leaving edge)
    logic shiftIn;   // shift SDI into the shifter (returning edge)
    logic loadRx;    // move the completed byte into the buffer
  } strobeT;

  localparam logic [3:0] MODE_DIV_A    = 4'd0;
  localparam logic [3:0] MODE_DIV_B    = 4'd1;
  localparam logic [3:0] MODE_DIV_C    = 4'd2;
  localparam logic [3:0] MODE_TICK     = 4'd3;
  localparam logic [3:0] MODE_SLV_SEL  = 4'd4;
  localparam logic [3:0] MODE_SLV_FREE = 4'd5;
endpackage

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
  import spi_port_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned DIV_A       = 4,
  parameter int unsigned DIV_B       = 16,
  parameter int unsigned DIV_C       = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWe,
  input  logic [7:0] ctrlWdata,
  input  logic       bufWe,
  input  logic       tickIn,
  input  logic       sckIn,
  input  logic       ssNIn,
  input  logic       bufFull,
  output logic [7:0] ctrlRdata,
  output strobeT     stb,
  output logic       busy,
  output logic       ssActive,
  output logic       sckOut,
  output logic       sckOe,
  output logic       sdoOe
);
  localparam int unsigned CNT_W = $clog2(DW);
  localparam int unsigned PRE_W = $clog2(DIV_C);

  logic [3:0] mode;
  logic       pol, en, ovf, wcol;
  logic       active, isMaster, isSlave;

  assign active   = en && (mode <= MODE_SLV_FREE);
  assign isMaster = active && (mode <= MODE_TICK);
  assign isSlave  = active && !isMaster;

  // Slave-side input synchronizers
  logic [SYNC_STAGES-1:0] sckSync, ssSync;
  logic sckPrev, sckS, ssS, actCur, actPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sckSync <= '0;
      ssSync  <= '1;
      sckPrev <= 1'b0;
    end else begin
      sckSync <= {sckSync[SYNC_STAGES-2:0], sckIn};
      ssSync  <= {ssSync[SYNC_STAGES-2:0], ssNIn};
      sckPrev <= sckS;
    end
  end

  assign sckS     = sckSync[SYNC_STAGES-1];
  assign ssS      = ssSync[SYNC_STAGES-1];
  assign actCur   = sckS ^ pol;
  assign actPrev  = sckPrev ^ pol;
  assign ssActive = isSlave && ((mode == MODE_SLV_FREE) || !ssS);

  // Master clock generation
  logic [PRE_W-1:0] preCnt, preTop;
  logic edgeTick, sckAct;

  always_comb begin
    case (mode)
      MODE_DIV_A: preTop = PRE_W'(DIV_A / 2 - 1);
      MODE_DIV_B: preTop = PRE_W'(DIV_B / 2 - 1);
      default:    preTop = PRE_W'(DIV_C / 2 - 1);
    endcase
  end

  assign edgeTick = (mode == MODE_TICK) ? tickIn : (preCnt == preTop);

  always_ff @(posedge clk) begin
    if (!rstN || !busy || edgeTick) preCnt <= '0;
    else                            preCnt <= preCnt + 1'b1;
  end

  // Edge events and bit counting
  logic [CNT_W-1:0] bitCnt;
  logic mLead, mTrail, sLead, sTrail, lead, trail, lastBit, done;
  logic slaveBusy, start, sLoad, collide;

  assign mLead     = isMaster && busy && edgeTick && !sckAct;
  assign mTrail    = isMaster && busy && edgeTick && sckAct;
  assign sLead     = ssActive && !actPrev && actCur;
  assign sTrail    = ssActive && actPrev && !actCur;
  assign lead      = mLead || sLead;
  assign trail     = mTrail || sTrail;
  assign lastBit   = (bitCnt == CNT_W'(DW - 1));
  assign done      = trail && lastBit;
  assign slaveBusy = (bitCnt != '0) || (ssActive && (actCur || actPrev));
  assign start     = isMaster && !busy && bufWe;
  assign sLoad     = isSlave && !slaveBusy && bufWe;
  assign collide   = bufWe && (isMaster ? busy : (isSlave && slaveBusy));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode <= '0; pol <= 1'b0; en <= 1'b0;
      ovf  <= 1'b0; wcol <= 1'b0;
      busy <= 1'b0; sckAct <= 1'b0; bitCnt <= '0;
    end else begin
      if (ctrlWe) begin
        mode <= ctrlWdata[3:0];
        pol  <= ctrlWdata[4];
        en   <= ctrlWdata[5];
      end
      wcol <= (wcol && !(ctrlWe && !ctrlWdata[7])) || collide;
      ovf  <= (ovf && !(ctrlWe && !ctrlWdata[6])) || (done && isSlave && bufFull);

      if (!isMaster)  busy <= 1'b0;
      else if (start) busy <= 1'b1;
      else if (done)  busy <= 1'b0;

      if (!isMaster)   sckAct <= 1'b0;
      else if (mLead)  sckAct <= 1'b1;
      else if (mTrail) sckAct <= 1'b0;

      if (!active || (isSlave && !ssActive) || start) bitCnt <= '0;
      else if (trail) bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
    end
  end

  assign stb.loadTx   = start || sLoad;
  assign stb.driveOut = lead;
  assign stb.shiftIn  = trail;
  assign stb.loadRx   = done && (isMaster || !bufFull);

  assign ctrlRdata = {wcol, ovf, en, pol, mode};
  assign sckOut    = pol ^ sckAct;
  assign sckOe     = isMaster;
  assign sdoOe     = isMaster || ssActive;
endmodule

// File: rtl/spi_port_dp.sv
module spi_port_dp
  import spi_port_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobeT        stb,
  input  logic [DW-1:0] bufWdata,
  input  logic          bufRe,
  input  logic          sdiIn,
  output logic [DW-1:0] bufRdata,
  output logic          bufFull,
  output logic          sdoOut
);
  logic [DW-1:0] shiftReg, rxBuf;
  logic          sdoReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      rxBuf    <= '0;
      sdoReg   <= 1'b0;
      bufFull  <= 1'b0;
    end else begin
      if (stb.loadTx)       shiftReg <= bufWdata;
      else if (stb.shiftIn) shiftReg <= {shiftReg[DW-2:0], sdiIn};

      if (stb.driveOut) sdoReg <= shiftReg[DW-1];

      if (stb.loadRx) begin
        rxBuf   <= {shiftReg[DW-2:0], sdiIn};
        bufFull <= 1'b1;
      end else if (bufRe) begin
        bufFull <= 1'b0;
      end
    end
  end

  assign bufRdata = rxBuf;
  assign sdoOut   = sdoReg;
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned DIV_A       = 4,
  parameter int unsigned DIV_B       = 16,
  parameter int unsigned DIV_C       = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ctrlWe,
  input  logic [7:0]    ctrlWdata,
  output logic [7:0]    ctrlRdata,
  input  logic          bufWe,
  input  logic [DW-1:0] bufWdata,
  input  logic          bufRe,
  output logic [DW-1:0] bufRdata,
  output logic          bufFull,
  input  logic          tickIn,
  input  logic          sckIn,
  output logic          sckOut,
  output logic          sckOe,
  input  logic          sdiIn,
  output logic          sdoOut,
  output logic          sdoOe,
  input  logic          ssNIn
);
  strobeT stb;
  logic   busy, ssActive, rxLoad;

  spi_port_ctrl #(
    .DW(DW), .DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .bufWe(bufWe), .tickIn(tickIn), .sckIn(sckIn), .ssNIn(ssNIn),
    .bufFull(bufFull), .ctrlRdata(ctrlRdata), .stb(stb), .busy(busy),
    .ssActive(ssActive), .sckOut(sckOut), .sckOe(sckOe), .sdoOe(sdoOe)
  );

  spi_port_dp #(.DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .bufWdata(bufWdata), .bufRe(bufRe),
    .sdiIn(sdiIn), .bufRdata(bufRdata), .bufFull(bufFull), .sdoOut(sdoOut)
  );

  assign rxLoad = stb.loadRx;
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic       clk,
  input logic       rstN,
  input logic       ctrlWe,
  input logic [7:0] ctrlWdata,
  input logic [7:0] ctrlRdata,
  input logic       bufRe,
  input logic       bufFull,
  input logic       rxLoad,
  input logic       busy,
  input logic       ssActive,
  input logic       sckOut,
  input logic       sckOe,
  input logic       sdoOe
);
  p_released_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlRdata[5] || ctrlRdata[3:0] > 4'd5) |-> (!sckOe && !sdoOe));

  p_idle_level_r11: assert property (@(posedge clk) disable iff (!rstN)
    (sckOe && !busy) |-> (sckOut == ctrlRdata[4]));

  p_wcol_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlRdata[7] && !(ctrlWe && !ctrlWdata[7])) |=> ctrlRdata[7]);

  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlRdata[6] && !(ctrlWe && !ctrlWdata[6])) |=> ctrlRdata[6]);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlRdata[5] && ctrlRdata[3:0] <= 4'd3 && !ctrlRdata[6]) |=> !ctrlRdata[6]);

  p_full_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    rxLoad |=> bufFull);

  p_full_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (bufRe && !rxLoad) |=> !bufFull);

  p_ss_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlRdata[5] && ctrlRdata[3:0] == 4'd4 && !ssActive) |-> !sdoOe);
endmodule

bind spi_port spi_port_chk u_chk (
  .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
  .ctrlRdata(ctrlRdata), .bufRe(bufRe), .bufFull(bufFull), .rxLoad(rxLoad),
  .busy(busy), .ssActive(ssActive), .sckOut(sckOut), .sckOe(sckOe), .sdoOe(sdoOe)
);

// File: tb/sim_spi_port.sv
`timescale 1ns/1ps
module sim_spi_port;
  logic clk = 1'b0, rstN = 1'b0;
  logic ctrlWe = 0, bufWe = 0, bufRe = 0, tickIn = 0, sckIn = 0, sdiIn = 0, ssNIn = 1;
  logic [7:0] ctrlWdata = 0, bufWdata = 0;
  logic [7:0] ctrlRdata, bufRdata;
  logic bufFull, sckOut, sckOe, sdoOut, sdoOe;

  int tests = 0, fails = 0, cyc = 0, ssCnt = 0;
  bit finished = 0, inMXfer = 0, tickOn = 0;
  logic [3:0] mMode = 0;
  logic mPol = 0, mEn = 0, ssPrev = 1;

  always #5 clk = ~clk;

  spi_port u0 (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata), .ctrlRdata(ctrlRdata),
    .bufWe(bufWe), .bufWdata(bufWdata), .bufRe(bufRe), .bufRdata(bufRdata), .bufFull(bufFull),
    .tickIn(tickIn), .sckIn(sckIn), .sckOut(sckOut), .sckOe(sckOe), .sdiIn(sdiIn),
    .sdoOut(sdoOut), .sdoOe(sdoOe), .ssNIn(ssNIn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  always @(posedge clk) begin
    #1 tickIn = tickOn && (cyc % 5 == 0);
  end

  // Per-clock reference comparison of the pin enables and the idle clock level
  always @(negedge clk) begin
    logic master, slave;
    if (ssNIn !== ssPrev) ssCnt = 0; else ssCnt++;
    ssPrev = ssNIn;
    if (rstN && !finished) begin
      master = mEn && (mMode <= 4'd3);
      slave  = mEn && (mMode == 4'd4 || mMode == 4'd5);
      chk("R10 sckOe per clock", sckOe, master);
      if (master || !slave || mMode == 4'd5)
        chk("R10 sdoOe per clock", sdoOe, master || slave);
      else if (ssCnt >= 4)
        chk("R8 sdoOe follows select", sdoOe, !ssNIn);
      if (!inMXfer) chk("R11 idle sck level", sckOut, mPol);
    end
  end

  task automatic tick1(); @(posedge clk); #1; endtask

  task automatic wrCtrl(input logic [7:0] d);
    ctrlWe = 1; ctrlWdata = d; tick1(); ctrlWe = 0;
    mMode = d[3:0]; mPol = d[4]; mEn = d[5];
  endtask

  task automatic wrBuf(input logic [7:0] d);
    bufWe = 1; bufWdata = d; tick1(); bufWe = 0;
  endtask

  task automatic rdBuf(output logic [7:0] d);
    d = bufRdata; bufRe = 1; tick1(); bufRe = 0;
  endtask

  task automatic countEdges(input int n, output int edges);
    logic p;
    p = sckOut; edges = 0;
    repeat (n) begin
      @(negedge clk);
      if (sckOut !== p) edges++;
      p = sckOut;
    end
    tick1();
  endtask

  // Bench acts as the far-end slave of a master transfer
  task automatic mXfer(input logic [7:0] tx, input logic [7:0] rxPat, input int half,
                       input string req);
    logic [7:0] cap; logic prevSck;
    int edges, lastCyc, badSp, bitI, guard;
    inMXfer = 1; sdiIn = rxPat[7]; bitI = 6; cap = 0;
    edges = 0; badSp = 0; lastCyc = -1; guard = 0;
    prevSck = sckOut;
    wrBuf(tx);
    while (edges < 16 && guard < 5000) begin
      @(negedge clk); guard++;
      if (sckOut !== prevSck) begin
        if (lastCyc >= 0 && (cyc - lastCyc) != half) badSp++;
        lastCyc = cyc; edges++;
        if (sckOut == mPol) begin
          cap = {cap[6:0], sdoOut};
          if (bitI >= 0) sdiIn = rxPat[bitI];
          bitI--;
        end
        prevSck = sckOut;
      end
    end
    tick1();
    inMXfer = 0;
    chk({req, " edge spacing"}, badSp, 0);
    chk({req, " edge count"}, edges, 16);
    chk("R3 master sdo byte msb first", cap, tx);
    chk("R3 master received byte", bufRdata, rxPat);
    chk("R3 bufFull after byte", bufFull, 1);
    chk("R7 no overflow in master", ctrlRdata[6], 0);
  endtask

  // Bench acts as the master of a slave transfer
  task automatic sXfer(input logic [7:0] rxPat, input int nbits, output logic [7:0] cap);
    cap = 0;
    for (int i = 0; i < nbits; i++) begin
      sckIn = ~mPol; sdiIn = rxPat[7 - i];
      repeat (8) tick1();
      cap = {cap[6:0], sdoOut};
      sckIn = mPol;
      repeat (8) tick1();
    end
    repeat (4) tick1();
  endtask

  initial begin
    logic [7:0] d, cap;
    int e;
    repeat (5) tick1();
    rstN = 1;
    tick1();
    chk("reset ctrl", ctrlRdata, 8'h00);
    chk("reset bufFull", bufFull, 0);
    chk("reset sckOe", sckOe, 0);
    chk("reset sdoOe", sdoOe, 0);

    // R10: disabled, then enabled with a reserved mode
    wrCtrl(8'h00);
    wrBuf(8'h55);
    countEdges(40, e);
    chk("R10 disabled no clocking", e, 0);
    chk("R10 disabled no collision", ctrlRdata[7], 0);
    wrCtrl(8'h27);
    chk("R10 reserved sckOe", sckOe, 0);
    chk("R10 reserved sdoOe", sdoOe, 0);
    wrBuf(8'h66);
    countEdges(40, e);
    chk("R10 reserved no clocking", e, 0);

    // R1 / R2 / R3 master transfers
    wrCtrl(8'h20);
    mXfer(8'hA5, 8'h3C, 2, "R1 div4");
    wrCtrl(8'h21);
    mXfer(8'h5A, 8'hC3, 8, "R1 div16");
    wrCtrl(8'h22);
    mXfer(8'h81, 8'h7E, 32, "R1 div64");
    wrCtrl(8'h23);
    tickOn = 1;
    mXfer(8'hF0, 8'h0F, 5, "R2 tick");
    tickOn = 0;

    // R7: second byte without reading replaces the buffer
    wrCtrl(8'h20);
    mXfer(8'h12, 8'h96, 2, "R7 unread refill");

    // R11: idle high
    wrCtrl(8'h30);
    tick1();
    chk("R11 idle high", sckOut, 1);
    mXfer(8'hC9, 8'h2D, 2, "R11 polarity high");
    rdBuf(d);
    chk("R4 bufFull cleared by read", bufFull, 0);

    // R5: write collision
    wrCtrl(8'h21);
    inMXfer = 1; sdiIn = 1;
    wrBuf(8'hC3);
    repeat (3) tick1();
    wrBuf(8'h11);
    chk("R5 collision flag set", ctrlRdata[7], 1);
    repeat (140) tick1();
    inMXfer = 0;
    chk("R5 first transfer undisturbed", bufRdata, 8'hFF);
    wrCtrl(8'hA1);
    chk("R5 writing one keeps flag", ctrlRdata[7], 1);
    wrCtrl(8'h21);
    chk("R5 writing zero clears flag", ctrlRdata[7], 0);
    rdBuf(d);

    // R9: slave ignoring select; R6 overflow
    sckIn = 0;
    wrCtrl(8'h25);
    repeat (4) tick1();
    wrBuf(8'hA5);
    sXfer(8'h3C, 8, cap);
    chk("R9 slave rx with select high", bufRdata, 8'h3C);
    chk("R9 slave bufFull", bufFull, 1);
    chk("R3 slave sdo byte msb first", cap, 8'hA5);
    sXfer(8'h81, 8, cap);
    chk("R6 overflow flag set", ctrlRdata[6], 1);
    chk("R6 old byte kept", bufRdata, 8'h3C);
    wrCtrl(8'h65);
    chk("R6 writing one keeps overflow", ctrlRdata[6], 1);
    wrCtrl(8'h25);
    chk("R6 overflow cleared", ctrlRdata[6], 0);
    rdBuf(d);
    chk("R4 bufFull cleared in slave", bufFull, 0);

    // R8: slave with select
    wrCtrl(8'h24);
    repeat (5) tick1();
    chk("R8 sdo released while deselected", sdoOe, 0);
    ssNIn = 0;
    repeat (5) tick1();
    chk("R8 sdo driven when selected", sdoOe, 1);
    sXfer(8'hF0, 3, cap);
    ssNIn = 1;
    repeat (6) tick1();
    chk("R8 sdo released mid byte", sdoOe, 0);
    ssNIn = 0;
    repeat (6) tick1();
    sXfer(8'h5A, 8, cap);
    chk("R8 count restarted after deselect", bufRdata, 8'h5A);
    chk("R8 bufFull after full byte", bufFull, 1);
    ssNIn = 1;
    repeat (6) tick1();

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule